// File: doc/BRIEF.md
# Dual 16-bit Multiply Add/Subtract Unit

This datapath treats each of two 32-bit operands as a pair of signed 16-bit halves. It multiplies the low half of one operand by the low half of the other, and the high half by the high half. The two products are then added or subtracted. An exchange control can swap the two halves of the second operand before the multiplication, which gives the cross products. The combined value can then go to one of two places. The first is a 32-bit path, where it is optionally added to a single accumulator word. The second is a 64-bit path, where it is added to an accumulator formed by a high word and a low word.

The unit sits in the execute stage of a processor pipeline. It receives register indices so that it can apply the register rules itself:
- An index of 15 is reserved.
- On the 32-bit path, an accumulator index of 15 turns the accumulate form into the plain product form.
- Illegal index combinations raise an unpredictable indicator and suppress every write.

Results, write enables, the saturation-flag set pulse and the unpredictable indicator are all registered. They appear one clock after the request.

Top module: `dual_mac16`

## Requirements
- R1: Each operand half is a signed 16-bit value. The low half comes from bits 15:0 and the high half from bits 31:16. Each half is sign-extended before multiplication, so 0x8000 counts as -32768.
- R2: When `swap_b` is 1, the two halves of `opnd_b` trade places before the products are formed. The low half of `opnd_a` then multiplies bits 31:16 of `opnd_b`, and the high half of `opnd_a` multiplies bits 15:0 of `opnd_b`.
- R3: In the 32-bit add form (`wide_sel`=0, `sub_sel`=0), `res_word` is the low product plus the high product plus the accumulator, taken modulo 2^32. `q_set` is 1 if either of two additions overflows as signed: the product sum, or the addition of the accumulator. When both overflow, `q_set` is still a single one-cycle pulse.
- R4: In the 32-bit subtract form (`sub_sel`=1), `res_word` is the low product minus the high product, plus the accumulator, modulo 2^32. No overflow check is made on the difference. Only the accumulator addition can set `q_set`, so the non-accumulating subtract never sets it.
- R5: In the 64-bit form (`wide_sel`=1), each product is sign-extended to 64 bits and summed or differenced. The result is then added to {`acc_hi`,`acc_lo`}, modulo 2^64. The result appears on `res_hi`/`res_lo` with `wr_pair`=1. `q_set` stays 0.
- R6: In the 32-bit forms, `idx_acc`=15 selects the non-accumulating operation and ignores `acc_word`. It is not flagged unpredictable.
- R7: A request raises `unpred` with no write and no `q_set` in either of these cases:
  - 32-bit form: 15 in `idx_dst`, `idx_a` or `idx_b`.
  - 64-bit form: 15 in `idx_dhi`, `idx_dlo`, `idx_a` or `idx_b`, or `idx_dhi` equal to `idx_dlo`.
- R8: A legal request with `cond_pass`=0 writes nothing and never sets `q_set`.
- R9: All outputs are registered, with one cycle of latency from `op_valid`. `wr_word`, `wr_pair`, `q_set` and `unpred` are single-cycle pulses. Synchronous active-low reset clears every output to 0. Result words hold their value between writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | Request strobe |
| cond_pass | input | 1 | Condition evaluated true |
| wide_sel | input | 1 | 1 selects the 64-bit accumulate form |
| sub_sel | input | 1 | 1 subtracts the high product from the low product |
| swap_b | input | 1 | 1 swaps the halves of opnd_b |
| idx_dst | input | 4 | Destination index, 32-bit form |
| idx_acc | input | 4 | Accumulator index, 32-bit form (15 means none) |
| idx_a | input | 4 | Index of the first operand |
| idx_b | input | 4 | Index of the second operand |
| idx_dhi | input | 4 | High destination index, 64-bit form |
| idx_dlo | input | 4 | Low destination index, 64-bit form |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| acc_word | input | 32 | 32-bit accumulator value |
| acc_hi | input | 32 | High word of the 64-bit accumulator |
| acc_lo | input | 32 | Low word of the 64-bit accumulator |
| res_word | output | 32 | 32-bit result |
| res_hi | output | 32 | High word of the 64-bit result |
| res_lo | output | 32 | Low word of the 64-bit result |
| wr_word | output | 1 | Write enable for res_word |
| wr_pair | output | 1 | Write enable for res_hi/res_lo |
| q_set | output | 1 | Saturation-flag set pulse |
| unpred | output | 1 | Unpredictable encoding indicator |

## Verification
The hardest case to reach is an overflow in the first stage, the sum of the two products. A 16x16 signed product can never exceed 0x40000000, so that sum overflows only when both halves of both operands are -32768. The stimulus therefore drives 0x80008000 into both operands. It repeats this with an accumulator of 0x80000000, so that both stages overflow in the same request, and checks that exactly one pulse results. The accumulator-index-15 fallback is reached by pairing an accumulator value that would overflow with index 15 and checking that the result and `q_set` ignore it.

// File: rtl/dual_mac16_pkg.sv
// Package: shared sizes and helpers for the dual 16-bit multiply unit.
// Assumes two's-complement operands; all other widths derive from HALF_W.
package dual_mac16_pkg;
    localparam int HALF_W  = 16;
    localparam int WORD_W  = 2 * HALF_W;
    localparam int PAIR_W  = 2 * WORD_W;
    localparam int IDX_W   = 4;
    localparam int LANES   = 2;

    // Lane selector for the two half products
    typedef enum logic {
        LANE_LO = 1'b0,
        LANE_HI = 1'b1
    } lane_e;

    // Signed overflow of x + y = s, judged on sign bits only
    function automatic logic add_ovf(input logic xs, input logic ys, input logic ss);
        return (xs == ys) && (ss != xs);
    endfunction
endpackage

// File: rtl/dmac_split.sv
// Module: dmac_split
// Splits both operands into signed halves and applies the optional
// half exchange to the second operand. Purely combinational.
// Assumes OP_W is even.
module dmac_split #(
    parameter int OP_W = 32
) (
    input  logic [OP_W-1:0]   opnd_a,
    input  logic [OP_W-1:0]   opnd_b,
    input  logic              swap_b,
    output logic [OP_W/2-1:0] a_half [2],
    output logic [OP_W/2-1:0] b_half [2]
);
    localparam int H = OP_W / 2;

    // Select the halves of opnd_b, exchanged when requested
    always_comb begin
        a_half[0] = opnd_a[H-1:0];
        a_half[1] = opnd_a[OP_W-1:H];
        if (swap_b) begin
            b_half[0] = opnd_b[OP_W-1:H];
            b_half[1] = opnd_b[H-1:0];
        end else begin
            b_half[0] = opnd_b[H-1:0];
            b_half[1] = opnd_b[OP_W-1:H];
        end
    end
endmodule

// File: rtl/dmac_lanes.sv
// Module: dmac_lanes
// Forms one signed product per lane: lane 0 is low x low, lane 1 is
// high x high. Inputs are signed halves of HALF_W bits; each product is
// exact in 2*HALF_W bits.
module dmac_lanes #(
    parameter int HALF_W = 16,
    parameter int NLANE  = 2
) (
    input  logic [HALF_W-1:0]   x_half [NLANE],
    input  logic [HALF_W-1:0]   y_half [NLANE],
    output logic [2*HALF_W-1:0] prod   [NLANE]
);
    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        logic signed [2*HALF_W-1:0] xs, ys;
        // Sign-extend the halves and multiply
        always_comb begin
            xs      = {{HALF_W{x_half[g][HALF_W-1]}}, x_half[g]};
            ys      = {{HALF_W{y_half[g][HALF_W-1]}}, y_half[g]};
            prod[g] = xs * ys;
        end
    end
endmodule

// File: rtl/dmac_decode.sv
// Module: dmac_decode
// Applies the register index rules: reserved index, equal destination
// pair, and the accumulator fallback. Assumes RSV is the reserved index.
module dmac_decode #(
    parameter int          IDX_W = 4,
    parameter logic [3:0]  RSV   = 4'd15
) (
    input  logic             wide_sel,
    input  logic [IDX_W-1:0] idx_dst,
    input  logic [IDX_W-1:0] idx_acc,
    input  logic [IDX_W-1:0] idx_a,
    input  logic [IDX_W-1:0] idx_b,
    input  logic [IDX_W-1:0] idx_dhi,
    input  logic [IDX_W-1:0] idx_dlo,
    output logic             bad_enc,
    output logic             use_acc
);
    logic src_bad, word_bad, pair_bad;

    // Classify the indices for the selected form
    always_comb begin
        src_bad  = (idx_a == IDX_W'(RSV)) || (idx_b == IDX_W'(RSV));
        word_bad = src_bad || (idx_dst == IDX_W'(RSV));
        pair_bad = src_bad || (idx_dhi == IDX_W'(RSV)) ||
                   (idx_dlo == IDX_W'(RSV)) || (idx_dhi == idx_dlo);
        bad_enc  = wide_sel ? pair_bad : word_bad;
        use_acc  = !wide_sel && (idx_acc != IDX_W'(RSV));
    end
endmodule

// File: rtl/dmac_combine.sv
// Module: dmac_combine
// Combines the two products into the 32-bit result with two overflow
// stages, and into the 64-bit result with sign-extended products.
// Assumes products are WORD_W bits, two's complement.
module dmac_combine #(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0]   p_lo,
    input  logic [WORD_W-1:0]   p_hi,
    input  logic                sub_sel,
    input  logic                use_acc,
    input  logic [WORD_W-1:0]   acc_word,
    input  logic [2*WORD_W-1:0] acc_pair,
    output logic [WORD_W-1:0]   word_res,
    output logic                word_ovf,
    output logic [2*WORD_W-1:0] pair_res
);
    import dual_mac16_pkg::add_ovf;
    localparam int MSB = WORD_W - 1;

    logic [WORD_W-1:0]   mid, addend;
    logic                ovf_mid, ovf_acc;
    logic [2*WORD_W-1:0] lo_x, hi_x, mid_x;

    // 32-bit path: product combine, then optional accumulator add
    always_comb begin
        if (sub_sel) begin
            mid     = p_lo - p_hi;
            ovf_mid = 1'b0;
        end else begin
            mid     = p_lo + p_hi;
            ovf_mid = add_ovf(p_lo[MSB], p_hi[MSB], mid[MSB]);
        end
        addend   = use_acc ? acc_word : '0;
        word_res = mid + addend;
        ovf_acc  = use_acc && add_ovf(mid[MSB], addend[MSB], word_res[MSB]);
        word_ovf = ovf_mid | ovf_acc;
    end

    // 64-bit path: widen each product before combining
    always_comb begin
        lo_x     = {{WORD_W{p_lo[MSB]}}, p_lo};
        hi_x     = {{WORD_W{p_hi[MSB]}}, p_hi};
        mid_x    = sub_sel ? (lo_x - hi_x) : (lo_x + hi_x);
        pair_res = mid_x + acc_pair;
    end
endmodule

// File: rtl/dual_mac16.sv
// Module: dual_mac16 (top)
// Dual signed 16-bit multiply with add/subtract of the products and
// optional 32-bit or 64-bit accumulation. One request per cycle, results
// registered with one cycle of latency. Synchronous active-low reset.
module dual_mac16 #(
    parameter int HALF_W = dual_mac16_pkg::HALF_W,
    parameter int IDX_W  = dual_mac16_pkg::IDX_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_valid,
    input  logic                cond_pass,
    input  logic                wide_sel,
    input  logic                sub_sel,
    input  logic                swap_b,
    input  logic [IDX_W-1:0]    idx_dst,
    input  logic [IDX_W-1:0]    idx_acc,
    input  logic [IDX_W-1:0]    idx_a,
    input  logic [IDX_W-1:0]    idx_b,
    input  logic [IDX_W-1:0]    idx_dhi,
    input  logic [IDX_W-1:0]    idx_dlo,
    input  logic [2*HALF_W-1:0] opnd_a,
    input  logic [2*HALF_W-1:0] opnd_b,
    input  logic [2*HALF_W-1:0] acc_word,
    input  logic [2*HALF_W-1:0] acc_hi,
    input  logic [2*HALF_W-1:0] acc_lo,
    output logic [2*HALF_W-1:0] res_word,
    output logic [2*HALF_W-1:0] res_hi,
    output logic [2*HALF_W-1:0] res_lo,
    output logic                wr_word,
    output logic                wr_pair,
    output logic                q_set,
    output logic                unpred
);
    import dual_mac16_pkg::*;
    localparam int WW = 2 * HALF_W;

    logic [HALF_W-1:0] a_half [LANES];
    logic [HALF_W-1:0] b_half [LANES];
    logic [WW-1:0]     prod   [LANES];
    logic              bad_enc, use_acc, word_ovf, fire;
    logic [WW-1:0]     word_res;
    logic [2*WW-1:0]   pair_res;

    dmac_split #(.OP_W(WW)) split_i (
        .opnd_a (opnd_a),
        .opnd_b (opnd_b),
        .swap_b (swap_b),
        .a_half (a_half),
        .b_half (b_half)
    );

    dmac_lanes #(.HALF_W(HALF_W), .NLANE(LANES)) lanes_i (
        .x_half (a_half),
        .y_half (b_half),
        .prod   (prod)
    );

    dmac_decode #(.IDX_W(IDX_W)) decode_i (
        .wide_sel (wide_sel),
        .idx_dst  (idx_dst),
        .idx_acc  (idx_acc),
        .idx_a    (idx_a),
        .idx_b    (idx_b),
        .idx_dhi  (idx_dhi),
        .idx_dlo  (idx_dlo),
        .bad_enc  (bad_enc),
        .use_acc  (use_acc)
    );

    dmac_combine #(.WORD_W(WW)) combine_i (
        .p_lo     (prod[LANE_LO]),
        .p_hi     (prod[LANE_HI]),
        .sub_sel  (sub_sel),
        .use_acc  (use_acc),
        .acc_word (acc_word),
        .acc_pair ({acc_hi, acc_lo}),
        .word_res (word_res),
        .word_ovf (word_ovf),
        .pair_res (pair_res)
    );

    // A request executes when legal and its condition holds
    always_comb fire = op_valid && !bad_enc && cond_pass;

    // Register pulses and results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_word <= '0;
            res_hi   <= '0;
            res_lo   <= '0;
            wr_word  <= 1'b0;
            wr_pair  <= 1'b0;
            q_set    <= 1'b0;
            unpred   <= 1'b0;
        end else begin
            wr_word <= fire && !wide_sel;
            wr_pair <= fire && wide_sel;
            q_set   <= fire && !wide_sel && word_ovf;
            unpred  <= op_valid && bad_enc;
            if (fire && !wide_sel) begin
                res_word <= word_res;
            end
            if (fire && wide_sel) begin
                {res_hi, res_lo} <= pair_res;
            end
        end
    end
endmodule

// File: rtl/dual_mac16_chk.sv
// Module: dual_mac16_chk
// Protocol and flag checks for dual_mac16, attached by bind.
// Assumes the reserved index is 15.
module dual_mac16_chk #(
    parameter int IDX_W = 4,
    parameter int WW    = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic             cond_pass,
    input logic             wide_sel,
    input logic             sub_sel,
    input logic [IDX_W-1:0] idx_dst,
    input logic [IDX_W-1:0] idx_acc,
    input logic [IDX_W-1:0] idx_a,
    input logic [IDX_W-1:0] idx_b,
    input logic [WW-1:0]    res_word,
    input logic             wr_word,
    input logic             wr_pair,
    input logic             q_set,
    input logic             unpred
);
    localparam logic [IDX_W-1:0] RSV = IDX_W'(15);

    a_r7_unpred_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        unpred |-> (!wr_word && !wr_pair && !q_set));

    a_r9_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_word, wr_pair, unpred}));

    a_r3_q_with_word: assert property (@(posedge clk) disable iff (!rst_n)
        q_set |-> wr_word);

    a_r5_pair_no_q: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && wide_sel) |=> !q_set);

    a_r4_plain_sub_no_q: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !wide_sel && sub_sel && idx_acc == RSV) |=> !q_set);

    a_r8_cond_fail: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !cond_pass) |=> (!wr_word && !wr_pair && !q_set));

    a_r6_acc_rsv_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !wide_sel && idx_dst != RSV && idx_a != RSV && idx_b != RSV)
        |=> !unpred);

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!wr_word && !wr_pair && !q_set && !unpred));

    a_r9_word_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(res_word));
endmodule

bind dual_mac16 dual_mac16_chk #(.IDX_W(IDX_W), .WW(2*HALF_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .cond_pass (cond_pass),
    .wide_sel  (wide_sel),
    .sub_sel   (sub_sel),
    .idx_dst   (idx_dst),
    .idx_acc   (idx_acc),
    .idx_a     (idx_a),
    .idx_b     (idx_b),
    .res_word  (res_word),
    .wr_word   (wr_word),
    .wr_pair   (wr_pair),
    .q_set     (q_set),
    .unpred    (unpred)
);

// File: tb/dual_mac16_tb_top.sv
`timescale 1ns/1ps
// Bench for dual_mac16: a vector table walked by one loop, then directed
// tests for reset, encoding rules, condition failure and corner cases.
module dual_mac16_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0, cond_pass = 1'b1;
    logic        wide_sel = 1'b0, sub_sel = 1'b0, swap_b = 1'b0;
    logic [3:0]  idx_dst = 4'd0, idx_acc = 4'd3, idx_a = 4'd1, idx_b = 4'd2;
    logic [3:0]  idx_dhi = 4'd4, idx_dlo = 4'd5;
    logic [31:0] opnd_a = '0, opnd_b = '0, acc_word = '0, acc_hi = '0, acc_lo = '0;
    logic [31:0] res_word, res_hi, res_lo;
    logic        wr_word, wr_pair, q_set, unpred;
    int          n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;   // 50 MHz

    dual_mac16 dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .cond_pass(cond_pass),
        .wide_sel(wide_sel), .sub_sel(sub_sel), .swap_b(swap_b),
        .idx_dst(idx_dst), .idx_acc(idx_acc), .idx_a(idx_a), .idx_b(idx_b),
        .idx_dhi(idx_dhi), .idx_dlo(idx_dlo), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .acc_word(acc_word), .acc_hi(acc_hi), .acc_lo(acc_lo),
        .res_word(res_word), .res_hi(res_hi), .res_lo(res_lo),
        .wr_word(wr_word), .wr_pair(wr_pair), .q_set(q_set), .unpred(unpred)
    );

    typedef struct packed {
        logic [31:0] a, b, acc, hi, lo;
        logic        swp, sub, wide;
        logic [3:0]  aidx;
        logic        eq;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        // R3 basic add with accumulator: 8+15+10 = 33
        '{32'h00030002, 32'h00050004, 32'd10, 32'd0, 32'd0, 1'b0, 1'b0, 1'b0, 4'd3, 1'b0},
        // R2 exchange: 10+12+10 = 32
        '{32'h00030002, 32'h00050004, 32'd10, 32'd0, 32'd0, 1'b1, 1'b0, 1'b0, 4'd3, 1'b0},
        // R1 sign extension, no accumulator
        '{32'h80007FFF, 32'hFFFF0002, 32'd5, 32'd0, 32'd0, 1'b0, 1'b0, 1'b0, 4'd15, 1'b0},
        // R3 both products 0x40000000: product sum overflows
        '{32'h80008000, 32'h80008000, 32'd0, 32'd0, 32'd0, 1'b0, 1'b0, 1'b0, 4'd15, 1'b1},
        // R3 both stages overflow: single pulse
        '{32'h80008000, 32'h80008000, 32'h80000000, 32'd0, 32'd0, 1'b0, 1'b0, 1'b0, 4'd2, 1'b1},
        // R3 accumulator stage overflow only
        '{32'h00010001, 32'h00010001, 32'h7FFFFFFF, 32'd0, 32'd0, 1'b0, 1'b0, 1'b0, 4'd6, 1'b1},
        // R4 subtract, difference zero, no overflow
        '{32'h80008000, 32'h80008000, 32'h7FFFFFFF, 32'd0, 32'd0, 1'b0, 1'b1, 1'b0, 4'd6, 1'b0},
        // R4 subtract, accumulator addition overflows
        '{32'h00000001, 32'h00000001, 32'h7FFFFFFF, 32'd0, 32'd0, 1'b0, 1'b1, 1'b0, 4'd6, 1'b1},
        // R4 non-accumulating subtract with large difference
        '{32'h80007FFF, 32'h80008000, 32'd0, 32'd0, 32'd0, 1'b0, 1'b1, 1'b0, 4'd15, 1'b0},
        // R6 accumulator index 15 ignores an overflowing accumulator
        '{32'h00000001, 32'h00000001, 32'h7FFFFFFF, 32'd0, 32'd0, 1'b0, 1'b1, 1'b0, 4'd15, 1'b0},
        // R5 wide add carries into high word
        '{32'h80008000, 32'h80008000, 32'd0, 32'h00000000, 32'h80000000, 1'b0, 1'b0, 1'b1, 4'd15, 1'b0},
        // R5 wide subtract with exchange on -1 pair
        '{32'h00020003, 32'h00040005, 32'd0, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, 1'b1, 1'b1, 4'd15, 1'b0},
        // R5 wide add of negative products
        '{32'hFFFFFFFF, 32'h00010001, 32'd0, 32'd0, 32'd0, 1'b0, 1'b0, 1'b1, 4'd15, 1'b0}
    };

    // Counted comparison; one FAIL line per mismatch
    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference result {word, hi, lo} computed with 64-bit integer arithmetic
    function automatic logic [95:0] model(input vec_t v);
        logic [31:0] bb;
        longint al, ah, bl, bh, pl, ph, s, p;
        bb = v.swp ? {v.b[15:0], v.b[31:16]} : v.b;
        al = longint'($signed(v.a[15:0]));
        ah = longint'($signed(v.a[31:16]));
        bl = longint'($signed(bb[15:0]));
        bh = longint'($signed(bb[31:16]));
        pl = al * bl;
        ph = ah * bh;
        s  = v.sub ? (pl - ph) : (pl + ph);
        p  = s + longint'({v.hi, v.lo});
        if (v.aidx != 4'd15) s = s + longint'($signed(v.acc));
        return {s[31:0], p[63:32], p[31:0]};
    endfunction

    // One-cycle request; outputs are sampled at the following falling edge
    task automatic issue();
        @(negedge clk);
        op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic load(input vec_t v);
        opnd_a = v.a; opnd_b = v.b; acc_word = v.acc; acc_hi = v.hi; acc_lo = v.lo;
        swap_b = v.swp; sub_sel = v.sub; wide_sel = v.wide; idx_acc = v.aidx;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [95:0] m;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 reset pulses", {60'd0, wr_word, wr_pair, q_set, unpred}, 64'd0);
        chk("R9 reset word", {32'd0, res_word}, 64'd0);
        chk("R9 reset pair", {res_hi, res_lo}, 64'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            load(VEC[i]);
            m = model(VEC[i]);
            issue();
            if (VEC[i].wide) begin
                chk("R5 pair result", {res_hi, res_lo}, m[63:0]);
                chk("R5 pair write", {62'd0, wr_pair, wr_word}, 64'd2);
                chk("R5 no q", {63'd0, q_set}, 64'd0);
            end else if (VEC[i].sub) begin
                chk("R4 word result", {32'd0, res_word}, {32'd0, m[95:64]});
                chk("R4 q", {63'd0, q_set}, {63'd0, VEC[i].eq});
                chk("R4 word write", {62'd0, wr_word, wr_pair}, 64'd2);
            end else begin
                chk("R3 word result", {32'd0, res_word}, {32'd0, m[95:64]});
                chk("R3 q", {63'd0, q_set}, {63'd0, VEC[i].eq});
                chk("R3 word write", {62'd0, wr_word, wr_pair}, 64'd2);
            end
            chk("R7 legal not flagged", {63'd0, unpred}, 64'd0);
        end

        // R1 directed: 0xFFFF * 0x8000 = -1 * -32768 = 32768
        load('{32'h0000FFFF, 32'h00008000, 32'd0, 32'd0, 32'd0, 1'b0, 1'b0, 1'b0, 4'd15, 1'b0});
        issue();
        chk("R1 sign-extended halves", {32'd0, res_word}, 64'h8000);

        // R2 directed: exchange pairs a_lo with b[31:16]
        load('{32'h00000003, 32'h00070000, 32'd0, 32'd0, 32'd0, 1'b1, 1'b0, 1'b0, 4'd15, 1'b0});
        issue();
        chk("R2 exchange", {32'd0, res_word}, 64'd21);

        // R9 pulses last one cycle; result holds
        @(negedge clk);
        chk("R9 pulse ends", {62'd0, wr_word, q_set}, 64'd0);
        chk("R9 word holds", {32'd0, res_word}, 64'd21);

        // R6 directed: index 15 ignores acc_word and is not unpredictable
        load('{32'h00000002, 32'h00000002, 32'h12345678, 32'd0, 32'd0, 1'b0, 1'b0, 1'b0, 4'd15, 1'b0});
        issue();
        chk("R6 no accumulate", {32'd0, res_word}, 64'd4);
        chk("R6 legal", {62'd0, unpred, wr_word}, 64'd1);

        // R7 destination 15 in the 32-bit form
        idx_dst = 4'd15;
        issue();
        chk("R7 dst rsv", {60'd0, unpred, wr_word, wr_pair, q_set}, 64'h8);
        chk("R7 word untouched", {32'd0, res_word}, 64'd4);
        idx_dst = 4'd0;

        // R7 operand index 15 with an overflowing request: no q
        load('{32'h80008000, 32'h80008000, 32'd0, 32'd0, 32'd0, 1'b0, 1'b0, 1'b0, 4'd15, 1'b1});
        idx_b = 4'd15;
        issue();
        chk("R7 operand rsv", {60'd0, unpred, wr_word, wr_pair, q_set}, 64'h8);
        idx_b = 4'd2;

        // R7 equal destination pair in the 64-bit form
        wide_sel = 1'b1; idx_dhi = 4'd5; idx_dlo = 4'd5;
        issue();
        chk("R7 equal pair", {60'd0, unpred, wr_word, wr_pair, q_set}, 64'h8);
        idx_dhi = 4'd4;
        // R7 destination 15 is legal in the 64-bit form when the pair is legal
        idx_dst = 4'd15;
        issue();
        chk("R7 pair ignores idx_dst", {60'd0, unpred, wr_word, wr_pair, q_set}, 64'h2);
        idx_dst = 4'd0; wide_sel = 1'b0;

        // R8 condition fails on an overflowing request
        cond_pass = 1'b0;
        issue();
        chk("R8 no write", {60'd0, unpred, wr_word, wr_pair, q_set}, 64'd0);
        chk("R8 word untouched", {32'd0, res_word}, 64'd4);
        cond_pass = 1'b1;

        // R9 synchronous reset clears outputs
        issue();
        chk("R9 q before reset", {63'd0, q_set}, 64'd1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9 reset clears", {res_word, 28'd0, wr_word, wr_pair, q_set, unpred}, 64'd0);
        rst_n = 1'b1;

        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule